// File: doc/BRIEF.md
# Key-Protected Watchdog Counter

This block is an 8-bit watchdog counter that sits on a small register bus. A 12-bit prescaler divides the clock. A 3-bit select code picks one of eight power-of-two ratios, from one step every 32 cycles to one step every 4096 cycles. Each time the selected prescaler tap reaches its terminal count, the counter advances by one. When the counter wraps from its top value to zero, the block sets a sticky overflow flag and emits a one-cycle pulse that a reset controller can use.

Each write is a 16-bit word. The high byte must hold the key that belongs to the target register: 0x5A for the counter (address 0) and 0xA5 for the control/status register (address 1). The low byte is the payload. A write with any other high byte is discarded and raises a sticky bad-key indication. Reads need no key. They are byte wide and combinational, selected by a separate read address. Control/status layout: bit 7 is the run enable, bits 6:4 are spare storage, bit 3 is the overflow flag, and bits 2:0 are the divide select.

The bus is a plain register interface with no valid/ready handshake. A write takes effect on the clock edge where `wr_en` is high. Every cycle can carry a write, so there is no back-pressure.

Top module: `keyed_wdt`

## Requirements
- R1: A write to address 0 with wr_data[15:8] = 0x5A loads wr_data[7:0] into the counter on that edge. Reading address 0 returns the counter.
- R2: A write to address 1 with wr_data[15:8] = 0xA5 loads bit 7 (enable), bits 6:4 (spare) and bits 2:0 (divide select) from the payload. Reading address 1 returns {enable, spare, flag, select}.
- R3: A write whose high byte is not the key of its target address changes no register. From the next cycle on, `bad_key` is high until reset.
- R4: After reset, the counter, the control/status register and `bad_key` are all zero, and `ovf_pulse` is low.
- R5: With enable set and select code s, the counter advances once every 2^(5+s) cycles. The first step comes 2^(5+s) cycles after the control/status write that enabled it.
- R6: While enable is clear, the prescaler and the counter hold their values.
- R7: A step from 0xFF to 0x00 sets the flag (bit 3) and makes `ovf_pulse` high for exactly the following cycle.
- R8: The flag clears only through an accepted control/status write with bit 3 = 0. Writing 1 to bit 3 never sets it.
- R9: An accepted control/status write clears the prescaler and suppresses a step in that cycle, so the new ratio starts from a fresh phase.
- R10: An accepted counter write in the same cycle as a step wins: the counter takes the written value and no overflow is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write target: 0 counter, 1 control/status |
| wr_data | input | 16 | Key in [15:8], payload in [7:0] |
| rd_addr | input | 1 | Read target: 0 counter, 1 control/status |
| rd_data | output | 8 | Selected register value |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| bad_key | output | 1 | Sticky rejected-write indication |

## Verification
The divide path is measured directly. For each of the eight select codes, the bench counts the cycles from an enabling control write to the first counter step, and then repeats the measurement after a mid-phase rewrite to show the prescaler phase is cleared. Directed sequences preload 0xFE to drive a wrap, which tells flag-set apart from pulse length. They then try a flag write of 1 and a flag write of 0, separating "write cannot set" from "write clears". A random phase mixes correct keys, crossed keys and garbage keys with dense counter writes at fast ratios. This forces collisions between loads and steps, and every cycle is compared against a cycle-level reference.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_CTRL  = 1'b1
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_FLAG_BIT = 3;
endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate #(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] CNT_KEY  = 8'h5A,
  parameter logic [KEY_W-1:0] CTRL_KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  wdt_pkg::reg_sel_e wr_sel,
  input  logic [KEY_W-1:0] wr_key,
  output logic             acc_cnt,
  output logic             acc_ctrl,
  output logic             bad_key
);
  logic key_ok;
  logic reject;

  always_comb begin
    key_ok = (wr_sel == wdt_pkg::SEL_COUNT) ? (wr_key == CNT_KEY)
                                            : (wr_key == CTRL_KEY);
    acc_cnt  = wr_en && key_ok && (wr_sel == wdt_pkg::SEL_COUNT);
    acc_ctrl = wr_en && key_ok && (wr_sel == wdt_pkg::SEL_CTRL);
    reject   = wr_en && !key_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bad_key <= 1'b0;
    else if (reject) bad_key <= 1'b1;
  end

  // R3
  bad_key_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_cnt && !acc_ctrl) |=> bad_key);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int MIN_LOG = 5,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_hit
);
  localparam int N_TAPS = 1 << SEL_W;
  localparam int PRE_W  = MIN_LOG + N_TAPS - 1;

  logic [PRE_W-1:0]  pre_q;
  logic [N_TAPS-1:0] term;

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= pre_q + PRE_W'(1);
  end

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign term[t] = &pre_q[MIN_LOG+t-1:0];
  end

  assign tap_hit = term[sel];

  // R6
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             ovf_pulse
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap = step && !load && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      if (load)      cnt_q <= load_val;
      else if (step) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);
  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)) && !ovf_pulse);
  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  input  logic             wrap,
  output logic             en,
  output logic [2:0]       spare,
  output logic             flag,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      spare <= '0;
      flag  <= 1'b0;
      sel   <= '0;
    end else begin
      if (wr) begin
        en    <= wdata[wdt_pkg::CTRL_EN_BIT];
        spare <= wdata[6:4];
        sel   <= wdata[SEL_W-1:0];
      end
      flag <= wrap || (flag && !(wr && !wdata[wdt_pkg::CTRL_FLAG_BIT]));
    end
  end

  // R7
  flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wrap));
  // R8
  flag_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr) && !$past(wdata[wdt_pkg::CTRL_FLAG_BIT]));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int CNT_W   = 8,
  parameter int SEL_W   = 3,
  parameter int MIN_LOG = 5,
  parameter logic [7:0] CNT_KEY  = 8'h5A,
  parameter logic [7:0] CTRL_KEY = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_addr,
  output logic [7:0]  rd_data,
  output logic        ovf_pulse,
  output logic        bad_key
);
  import wdt_pkg::*;

  logic             acc_cnt, acc_ctrl;
  logic             en, flag, tap_hit, step, wrap;
  logic [2:0]       spare;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] cnt_q;
  reg_sel_e         wsel;

  assign wsel = reg_sel_e'(wr_addr);

  wdt_keygate #(.KEY_W(8), .CNT_KEY(CNT_KEY), .CTRL_KEY(CTRL_KEY)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wsel),
    .wr_key(wr_data[15:8]), .acc_cnt(acc_cnt), .acc_ctrl(acc_ctrl),
    .bad_key(bad_key));

  wdt_ctrl_reg #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(acc_ctrl), .wdata(wr_data[7:0]),
    .wrap(wrap), .en(en), .spare(spare), .flag(flag), .sel(sel));

  wdt_prescaler #(.MIN_LOG(MIN_LOG), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en), .clr(acc_ctrl), .sel(sel),
    .tap_hit(tap_hit));

  assign step = en && tap_hit && !acc_ctrl;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(acc_cnt), .load_val(wr_data[CNT_W-1:0]),
    .step(step), .cnt_q(cnt_q), .wrap(wrap), .ovf_pulse(ovf_pulse));

  always_comb begin
    if (reg_sel_e'(rd_addr) == SEL_CTRL)
      rd_data = {en, spare, flag, 3'(sel)};
    else
      rd_data = 8'(cnt_q);
  end

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ctrl |=> (en == $past(wr_data[7])) && (sel == $past(wr_data[SEL_W-1:0])));
  // R3
  reject_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_cnt && !acc_ctrl && !step) |=> $stable(cnt_q));
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [7:0]  rd_data;
  logic        ovf_pulse, bad_key;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [11:0] m_pre;
  logic [7:0]  m_cnt;
  logic        m_en, m_flag, m_pulse, m_bad;
  logic [2:0]  m_spare, m_sel;

  always #4 clk = ~clk;

  keyed_wdt i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_pulse(ovf_pulse), .bad_key(bad_key));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic a);
    return a ? {m_en, m_spare, m_flag, m_sel} : m_cnt;
  endfunction

  function automatic bit tap_term(input logic [11:0] p, input logic [2:0] s);
    logic [11:0] mask = 12'((1 << (5 + s)) - 1);
    return (p & mask) == mask;
  endfunction

  task automatic model_reset();
    m_pre = '0; m_cnt = '0; m_en = 0; m_flag = 0; m_pulse = 0;
    m_bad = 0; m_spare = '0; m_sel = '0;
  endtask

  task automatic cyc(input logic we, input logic a, input logic [15:0] d, input logic ra);
    logic ok_c, ok_s, tick, wrp;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
    @(posedge clk);
    ok_c = we && !a && d[15:8] == 8'h5A;
    ok_s = we && a && d[15:8] == 8'hA5;
    tick = m_en && tap_term(m_pre, m_sel) && !ok_s;
    wrp  = tick && !ok_c && m_cnt == 8'hFF;
    if (we && !ok_c && !ok_s) m_bad = 1;
    m_pulse = wrp;
    m_flag  = wrp || (m_flag && !(ok_s && !d[3]));
    m_pre   = ok_s ? 12'd0 : (m_en ? m_pre + 12'd1 : m_pre);
    if (ok_c) m_cnt = d[7:0];
    else if (tick) m_cnt = m_cnt + 8'd1;
    if (ok_s) begin m_en = d[7]; m_spare = d[6:4]; m_sel = d[2:0]; end
    #2;
    check(rd_data == exp_read(ra), ra ? "R2 ctrl read" : "R1/R5 count read",
          rd_data, exp_read(ra));
    check(ovf_pulse == m_pulse, "R7 pulse", ovf_pulse, m_pulse);
    check(bad_key == m_bad, "R3 bad_key", bad_key, m_bad);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, 0);
  endtask

  // cycles from an enabling write to the first counter step
  task automatic measure(input logic [2:0] s, input string req);
    int n = 0;
    cyc(1, 0, 16'h5A00, 0);
    cyc(1, 1, {8'hA5, 1'b1, 4'b0, s}, 0);
    while (rd_data == 8'h00 && n < 5000) begin
      cyc(0, 0, 16'h0, 0);
      n++;
    end
    check(n == (1 << (5 + s)), req, n, 1 << (5 + s));
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R4 reset state
    check(rd_data == 8'h00, "R4 count after reset", rd_data, 0);
    rd_addr = 1; #1;
    check(rd_data == 8'h00, "R4 ctrl after reset", rd_data, 0);
    check(!ovf_pulse && !bad_key, "R4 outputs after reset", {ovf_pulse, bad_key}, 0);

    // R1 keyed count load, R2 keyed ctrl load with spare bits, disabled
    cyc(1, 0, 16'h5A37, 0);
    check(rd_data == 8'h37, "R1 count load", rd_data, 8'h37);
    cyc(1, 1, 16'hA576, 1);
    check(rd_data == 8'h76 && m_flag == 0, "R2 ctrl load flag stays 0", rd_data, 8'h76);

    // R6 disabled: nothing moves
    idle(200);
    cyc(0, 0, 16'h0, 0);
    check(rd_data == 8'h37, "R6 hold while disabled", rd_data, 8'h37);

    // R5 each divide ratio
    for (int s = 0; s < 8; s++) measure(3'(s), "R5 divide period");

    // R9 mid-phase rewrite restarts the phase
    cyc(1, 0, 16'h5A00, 0);
    cyc(1, 1, 16'hA580, 0);
    idle(20);
    measure(3'd0, "R9 phase cleared");

    // R3 wrong keys: crossed and garbage
    cyc(1, 1, 16'h5A00, 1);
    check(rd_data == 8'h80, "R3 crossed key ignored", rd_data, 8'h80);
    cyc(1, 0, 16'h1299, 0);
    check(rd_data != 8'h99 && bad_key, "R3 garbage key ignored", rd_data, m_cnt);

    // R7 wrap and R8 flag behaviour
    cyc(1, 0, 16'h5AFE, 0);
    cyc(1, 1, 16'hA580, 1);
    idle(70);
    cyc(0, 0, 16'h0, 1);
    check(rd_data[3] == 1'b1, "R7 flag set after wrap", rd_data, 8'h88);
    cyc(1, 1, 16'hA588, 1);
    check(rd_data[3] == 1'b1, "R8 write 1 keeps flag", rd_data[3], 1);
    cyc(1, 1, 16'hA580, 1);
    check(rd_data[3] == 1'b0, "R8 write 0 clears flag", rd_data[3], 0);
    cyc(1, 1, 16'hA508, 1);
    check(rd_data[3] == 1'b0, "R8 write 1 cannot set", rd_data[3], 0);

    // random phase: R10 collisions, keys, wraps
    for (int i = 0; i < 6000; i++) begin
      logic we, a;
      logic [15:0] d;
      logic [7:0] key;
      int r = $urandom_range(0, 99);
      we = (r < 18);
      a  = $urandom_range(0, 1);
      if ($urandom_range(0, 9) < 8) key = a ? 8'hA5 : 8'h5A;
      else key = 8'($urandom);
      if (a) d = {key, ($urandom_range(0, 9) != 0), 3'($urandom), 1'($urandom),
                  2'b00, 1'($urandom_range(0, 1))};
      else   d = {key, 8'($urandom_range(8'hF0, 8'hFF))};
      cyc(we, a, d, 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule